// File: doc/BRIEF.md
# Single-Bit Boolean Unit

This unit carries out the one-bit instructions of a small microcontroller core. A single status bit, the carry, serves as a Boolean accumulator. Any bit in the directly addressable bit space can be cleared, set, inverted, copied to or from the carry, folded into the carry by AND or OR (optionally inverted), or tested to decide a branch. An 8-bit bit address is turned into a byte address and a bit index. The containing byte is read through a simple byte port, and a changed byte is written back whole with only the selected bit altered.

The status byte is held inside the unit, and the carry is its top bit. Bit addresses that fall in that byte go to the internal register and never reach the memory port, so a bit write there changes the flags directly. The core presents one operation at a time with `opValid` while `opReady` is high. After one or two execute cycles, the unit pulses `done` together with `taken` for branch operations. Branch target arithmetic and the memory array are outside the unit. The read port is combinational: `memRdData` reflects `memAddr` in the same cycle.

Top module: `bit_engine`

## Requirements
- R1: A bit address below 0x80 selects byte 0x20 plus address bits 6..3, with bit index taken from address bits 2..0. That byte address appears on `memAddr` during the cycle in which the byte is read.
- R2: A bit address of 0x80 or above selects the byte at the address with its low three bits cleared, with bit index taken from address bits 2..0.
- R3: Codes 0, 1 and 2 clear, set and invert the carry, which is `flags` bit 7.
- R4: Codes 3, 4 and 5 clear, set and invert the addressed bit. The byte is written back with the other seven bits unchanged.
- R5: Code 6 copies the addressed bit into the carry. Code 7 writes the carry into the addressed bit.
- R6: Codes 8, 9, 10 and 11 set the carry to carry AND bit, carry AND NOT bit, carry OR bit and carry OR NOT bit respectively.
- R7: Code 12 raises `taken` when the bit is 1. Code 13 raises `taken` when the bit is 0.
- R8: Code 14 raises `taken` only when the bit is 1, and in that case writes the bit back as 0. When the bit is 0 it performs no write.
- R9: Code 15 raises `taken` when the carry is 1. Code 16 raises `taken` when the carry is 0.
- R10: Bit addresses 0xD0 to 0xD7 address the internal status byte, with bit 0xD7 being the carry. Reads and writes there act on `flags` and produce no memory-port read or write.
- R11: Codes 7 through 16 finish two cycles after acceptance; all others finish after one. `done` is a single-cycle pulse, and `flags` change only at the end of a `done` cycle.
- R12: After reset `flags` is 0, `opReady` is 1 and `done` is 0. `opReady` stays low from acceptance until the operation has finished.
- R13: Codes 17 to 31 finish after one cycle with no memory access, no change to `flags` and `taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented |
| opCode | input | 5 | Operation code (see requirements) |
| bitAddr | input | 8 | Bit address of the operand |
| opReady | output | 1 | Unit is idle and accepts an operation |
| memRdEn | output | 1 | Byte read from the memory port this cycle |
| memAddr | output | 8 | Byte address for the memory port |
| memRdData | input | 8 | Read data, valid in the same cycle as `memAddr` |
| memWrEn | output | 1 | Write `memWrData` to `memAddr` at this clock edge |
| memWrData | output | 8 | Read byte with the selected bit replaced |
| done | output | 1 | Last cycle of the operation |
| taken | output | 1 | Branch condition met, valid with `done` |
| carry | output | 1 | Current carry |
| flags | output | 8 | Internal status byte, carry in bit 7 |

## Verification
The assertions assume that `memRdData` is a stable, known function of `memAddr` in a cycle with a read. The one-bit-difference check on write-back relies on this. They also assume that `opValid` is offered only while the unit is ready, or that it is harmless when the unit is busy. The bench drives its own combinational memory from `memAddr`. It loads each target byte before the operation, in a separate idle cycle, and raises `opValid` for a single cycle at a time. The sweep covers every code against every bit address, with the carry set both ways, so the status byte region and both address halves are reached for every operation.

// File: rtl/bit_engine_pkg.sv
package bit_engine_pkg;

  typedef enum logic [4:0] {
    OP_CY_CLR     = 5'd0,
    OP_CY_SET     = 5'd1,
    OP_CY_INV     = 5'd2,
    OP_BIT_CLR    = 5'd3,
    OP_BIT_SET    = 5'd4,
    OP_BIT_INV    = 5'd5,
    OP_LOAD_CY    = 5'd6,
    OP_STORE_CY   = 5'd7,
    OP_AND        = 5'd8,
    OP_AND_NOT    = 5'd9,
    OP_OR         = 5'd10,
    OP_OR_NOT     = 5'd11,
    OP_BR_SET     = 5'd12,
    OP_BR_CLR     = 5'd13,
    OP_BR_SET_CLR = 5'd14,
    OP_BR_CY      = 5'd15,
    OP_BR_NCY     = 5'd16
  } bitOp_e;

  typedef struct packed {
    logic capture;
    logic fire;
    logic readByte;
    logic writeBit;
    logic writeIfSet;
    logic writeCarry;
  } ctrlStrobes_t;

  function automatic logic opIsLong(input logic [4:0] op);
    case (bitOp_e'(op))
      OP_STORE_CY, OP_AND, OP_AND_NOT, OP_OR, OP_OR_NOT,
      OP_BR_SET, OP_BR_CLR, OP_BR_SET_CLR, OP_BR_CY, OP_BR_NCY: opIsLong = 1'b1;
      default: opIsLong = 1'b0;
    endcase
  endfunction

  function automatic logic opReadsByte(input logic [4:0] op);
    case (bitOp_e'(op))
      OP_BIT_CLR, OP_BIT_SET, OP_BIT_INV, OP_LOAD_CY, OP_STORE_CY,
      OP_AND, OP_AND_NOT, OP_OR, OP_OR_NOT,
      OP_BR_SET, OP_BR_CLR, OP_BR_SET_CLR: opReadsByte = 1'b1;
      default: opReadsByte = 1'b0;
    endcase
  endfunction

  function automatic logic opWritesBit(input logic [4:0] op);
    case (bitOp_e'(op))
      OP_BIT_CLR, OP_BIT_SET, OP_BIT_INV, OP_STORE_CY: opWritesBit = 1'b1;
      default: opWritesBit = 1'b0;
    endcase
  endfunction

  function automatic logic opWritesCarry(input logic [4:0] op);
    case (bitOp_e'(op))
      OP_CY_CLR, OP_CY_SET, OP_CY_INV, OP_LOAD_CY,
      OP_AND, OP_AND_NOT, OP_OR, OP_OR_NOT: opWritesCarry = 1'b1;
      default: opWritesCarry = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bit_engine_map.sv
module bit_engine_map #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W = $clog2(DATA_W),
  parameter logic [ADDR_W-1:0] RAM_BASE = 'h20,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD0
) (
  input  logic [ADDR_W-1:0] bitAddr,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              isFlagByte
);
  localparam int OFS_W = ADDR_W - 1 - IDX_W;

  logic [OFS_W-1:0]  ramOffset;
  logic [ADDR_W-1:0] ramByte;
  logic [ADDR_W-1:0] sfrByte;

  // lower half: a packed window of bit-addressable RAM bytes
  assign ramOffset = bitAddr[ADDR_W-2:IDX_W];
  assign ramByte   = RAM_BASE + ADDR_W'(ramOffset);
  // upper half: every register on an aligned byte boundary
  assign sfrByte   = {bitAddr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};

  assign byteAddr   = bitAddr[ADDR_W-1] ? sfrByte : ramByte;
  assign bitIdx     = bitAddr[IDX_W-1:0];
  assign isFlagByte = (byteAddr == FLAG_ADDR);
endmodule

// File: rtl/bit_engine_ctrl.sv
module bit_engine_ctrl
  import bit_engine_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [4:0]   opCode,
  output logic         opReady,
  output logic [4:0]   curOp,
  output ctrlStrobes_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_FIRE} state_e;

  state_e     stateQ, stateD;
  logic [4:0] opQ;
  logic       accept;

  assign accept  = opValid && (stateQ == ST_IDLE);
  assign opReady = (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (accept) stateD = opIsLong(opCode) ? ST_HOLD : ST_FIRE;
      ST_HOLD: stateD = ST_FIRE;
      ST_FIRE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ    <= '0;
    end else begin
      stateQ <= stateD;
      if (accept) opQ <= opCode;
    end
  end

  logic firing;
  assign firing = (stateQ == ST_FIRE);

  assign curOp              = opQ;
  assign strobes.capture    = accept;
  assign strobes.fire       = firing;
  assign strobes.readByte   = firing && opReadsByte(opQ);
  assign strobes.writeBit   = firing && opWritesBit(opQ);
  assign strobes.writeIfSet = firing && (opQ == OP_BR_SET_CLR);
  assign strobes.writeCarry = firing && opWritesCarry(opQ);
endmodule

// File: rtl/bit_engine_dp.sv
module bit_engine_dp
  import bit_engine_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W = $clog2(DATA_W),
  parameter logic [ADDR_W-1:0] RAM_BASE = 'h20,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [4:0]        curOp,
  input  logic [ADDR_W-1:0] bitAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              taken,
  output logic [DATA_W-1:0] flags
);
  localparam int CY_POS = DATA_W - 1;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] flagsQ;
  logic [ADDR_W-1:0] byteAddr;
  logic [IDX_W-1:0]  bitIdx;
  logic              isFlagByte;

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (strobes.capture) addrQ <= bitAddr;
  end

  bit_engine_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .RAM_BASE(RAM_BASE), .FLAG_ADDR(FLAG_ADDR)
  ) u_map (
    .bitAddr(addrQ),
    .byteAddr(byteAddr),
    .bitIdx(bitIdx),
    .isFlagByte(isFlagByte)
  );

  logic [DATA_W-1:0] srcByte;
  logic              bitVal;
  logic              cyVal;

  assign srcByte = isFlagByte ? flagsQ : memRdData;
  assign bitVal  = srcByte[bitIdx];
  assign cyVal   = flagsQ[CY_POS];

  logic newBit;
  logic newCarry;
  logic branchHit;

  always_comb begin
    newBit    = 1'b0;
    newCarry  = cyVal;
    branchHit = 1'b0;
    case (bitOp_e'(curOp))
      OP_CY_CLR:     newCarry = 1'b0;
      OP_CY_SET:     newCarry = 1'b1;
      OP_CY_INV:     newCarry = ~cyVal;
      OP_BIT_CLR:    newBit = 1'b0;
      OP_BIT_SET:    newBit = 1'b1;
      OP_BIT_INV:    newBit = ~bitVal;
      OP_LOAD_CY:    newCarry = bitVal;
      OP_STORE_CY:   newBit = cyVal;
      OP_AND:        newCarry = cyVal & bitVal;
      OP_AND_NOT:    newCarry = cyVal & ~bitVal;
      OP_OR:         newCarry = cyVal | bitVal;
      OP_OR_NOT:     newCarry = cyVal | ~bitVal;
      OP_BR_SET:     branchHit = bitVal;
      OP_BR_CLR:     branchHit = ~bitVal;
      OP_BR_SET_CLR: begin
        branchHit = bitVal;
        newBit    = 1'b0;
      end
      OP_BR_CY:      branchHit = cyVal;
      OP_BR_NCY:     branchHit = ~cyVal;
      default: begin
        newBit    = 1'b0;
        newCarry  = cyVal;
        branchHit = 1'b0;
      end
    endcase
  end

  // read-modify-write: only the indexed lane takes the new value
  logic [DATA_W-1:0] modByte;
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign modByte[i] = (bitIdx == IDX_W'(i)) ? newBit : srcByte[i];
  end

  logic doWrite;
  assign doWrite = strobes.writeBit || (strobes.writeIfSet && bitVal);

  assign memAddr   = byteAddr;
  assign memRdEn   = strobes.readByte && !isFlagByte;
  assign memWrEn   = doWrite && !isFlagByte;
  assign memWrData = modByte;
  assign taken     = strobes.fire && branchHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (doWrite && isFlagByte) begin
      flagsQ <= modByte;
    end else if (strobes.writeCarry) begin
      flagsQ[CY_POS] <= newCarry;
    end
  end

  assign flags = flagsQ;
endmodule

// File: rtl/bit_engine.sv
module bit_engine
  import bit_engine_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 'h20,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [4:0]        opCode,
  input  logic [ADDR_W-1:0] bitAddr,
  output logic              opReady,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              done,
  output logic              taken,
  output logic              carry,
  output logic [DATA_W-1:0] flags
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CY_POS = DATA_W - 1;

  ctrlStrobes_t strobes;
  logic [4:0]   curOp;

  bit_engine_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .opValid(opValid),
    .opCode(opCode),
    .opReady(opReady),
    .curOp(curOp),
    .strobes(strobes)
  );

  bit_engine_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .RAM_BASE(RAM_BASE), .FLAG_ADDR(FLAG_ADDR)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .curOp(curOp),
    .bitAddr(bitAddr),
    .memRdData(memRdData),
    .memRdEn(memRdEn),
    .memAddr(memAddr),
    .memWrEn(memWrEn),
    .memWrData(memWrData),
    .taken(taken),
    .flags(flags)
  );

  assign done  = strobes.fire;
  assign carry = flags[CY_POS];
endmodule

// File: rtl/bit_engine_chk.sv
module bit_engine_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 'h20,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'hD0
) (
  input logic              clk,
  input logic              rstN,
  input logic              opReady,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memRdData,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memWrData,
  input logic              done,
  input logic              taken,
  input logic [DATA_W-1:0] flags
);
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] RAM_LAST = RAM_BASE + ADDR_W'((1 << (ADDR_W - 1 - $clog2(DATA_W))) - 1);

  assert_ram_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memAddr < HALF) |-> (memAddr >= RAM_BASE && memAddr <= RAM_LAST));

  assert_sfr_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memAddr >= HALF) |-> (memAddr % DATA_W == 0));

  assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($countones(memWrData ^ memRdData) <= 1));

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memRdEn);

  assert_taken_in_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> done);

  assert_flag_private_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> (memAddr != FLAG_ADDR));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(flags));

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !opReady);
endmodule

bind bit_engine bit_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BASE(RAM_BASE), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .opReady(opReady),
  .memRdEn(memRdEn),
  .memAddr(memAddr),
  .memRdData(memRdData),
  .memWrEn(memWrEn),
  .memWrData(memWrData),
  .done(done),
  .taken(taken),
  .flags(flags)
);

// File: tb/bit_engine_test.sv
`timescale 1ns/1ps
module bit_engine_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] bitAddr = '0;
  logic       opReady, memRdEn, memWrEn, done, taken, carry;
  logic [7:0] memAddr, memRdData, memWrData, flags;

  always #2.5 clk = ~clk;

  bit_engine uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .bitAddr(bitAddr),
    .opReady(opReady), .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .done(done), .taken(taken),
    .carry(carry), .flags(flags)
  );

  logic [7:0] mem [256];
  logic       presetEn = 1'b0;
  logic [7:0] presetAddr = '0;
  logic [7:0] presetData = '0;

  assign memRdData = mem[memAddr];
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    else if (presetEn) mem[presetAddr] <= presetData;
  end

  int nChecks = 0;
  int nFails = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic preset(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    presetEn = 1'b1; presetAddr = a; presetData = d;
    @(posedge clk);
    @(negedge clk);
    presetEn = 1'b0;
  endtask

  task automatic runOp(input logic [4:0] code, input logic [7:0] a,
                       output int lat, output logic rdyBusy, output logic tk,
                       output logic rd, output logic wr,
                       output logic [7:0] ad, output logic [7:0] wd);
    @(negedge clk);
    opValid = 1'b1; opCode = code; bitAddr = a;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    rdyBusy = opReady;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    tk = taken; rd = memRdEn; wr = memWrEn; ad = memAddr; wd = memWrData;
    @(negedge clk);
  endtask

  function automatic string tagOf(input int code, input bit inFlags);
    if (inFlags && code >= 3 && code <= 14) return "R10";
    if (code <= 2) return "R3";
    if (code <= 5) return "R4";
    if (code <= 7) return "R5";
    if (code <= 11) return "R6";
    if (code <= 13) return "R7";
    if (code == 14) return "R8";
    if (code <= 16) return "R9";
    return "R13";
  endfunction

  logic [7:0] fM = '0;

  initial begin
    int lat;
    logic rb, tk, rd, wr;
    logic [7:0] ad, wd;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(opReady == 1'b1, "R12", "opReady after reset", opReady, 1);
    check(done == 1'b0, "R12", "done after reset", done, 0);
    check(flags == 8'h00, "R12", "flags after reset", flags, 0);
    rstN = 1'b1;

    for (int k = 0; k < 19; k++) begin
      for (int a = 0; a < 256; a++) begin
        logic [4:0] code;
        logic       cyPre, isF, b, c, nb, nc, expTk, expRd, expWr, expCw, isLong;
        logic [7:0] ab, eb, pv, src, nByte;
        logic [2:0] bi;
        string      tg;
        code  = (k < 17) ? 5'(k) : ((k == 17) ? 5'd17 : 5'd31);
        ab    = 8'(a);
        cyPre = ((a >> 1) ^ k) & 1;

        runOp(cyPre ? 5'd1 : 5'd0, 8'h00, lat, rb, tk, rd, wr, ad, wd);
        fM[7] = cyPre;
        check(flags == fM, "R3", "carry preset", flags, fM);

        // R1 / R2 address arithmetic
        eb  = (a < 128) ? 8'(8'h20 + (a >> 3)) : 8'(a & 8'hF8);
        bi  = ab[2:0];
        isF = (eb == 8'hD0);
        pv  = 8'((a * 29 + k * 53 + 7) ^ (a >> 2));
        if (!isF) preset(eb, pv);

        src = isF ? fM : pv;
        b = src[bi];
        c = fM[7];
        nb = 1'b0; nc = c; expTk = 1'b0; expWr = 1'b0; expCw = 1'b0;
        expRd  = (code >= 3 && code <= 14);
        isLong = (code >= 7 && code <= 16);
        case (code)
          5'd0:  begin nc = 1'b0; expCw = 1; end
          5'd1:  begin nc = 1'b1; expCw = 1; end
          5'd2:  begin nc = ~c; expCw = 1; end
          5'd3:  begin nb = 1'b0; expWr = 1; end
          5'd4:  begin nb = 1'b1; expWr = 1; end
          5'd5:  begin nb = ~b; expWr = 1; end
          5'd6:  begin nc = b; expCw = 1; end
          5'd7:  begin nb = c; expWr = 1; end
          5'd8:  begin nc = c & b; expCw = 1; end
          5'd9:  begin nc = c & ~b; expCw = 1; end
          5'd10: begin nc = c | b; expCw = 1; end
          5'd11: begin nc = c | ~b; expCw = 1; end
          5'd12: expTk = b;
          5'd13: expTk = ~b;
          5'd14: begin expTk = b; expWr = b; nb = 1'b0; end
          5'd15: expTk = c;
          5'd16: expTk = ~c;
          default: ;
        endcase
        nByte = src;
        nByte[bi] = nb;
        if (expWr && isF) fM = nByte;
        else if (expCw) fM[7] = nc;

        tg = tagOf(int'(code), isF);
        runOp(code, ab, lat, rb, tk, rd, wr, ad, wd);

        check(lat == (isLong ? 2 : 1), "R11", "latency", lat, isLong ? 2 : 1);
        check(rb == 1'b0, "R12", "opReady while busy", rb, 0);
        check(tk == expTk, tg, "taken", tk, expTk);
        check(rd == (expRd && !isF), tg, "memRdEn", rd, expRd && !isF);
        check(wr == (expWr && !isF), tg, "memWrEn", wr, expWr && !isF);
        if (rd) check(ad == eb, (a < 128) ? "R1" : "R2", "read byte address", ad, eb);
        if (expWr && !isF) begin
          check(wd == nByte, tg, "write-back byte", wd, nByte);
          check(mem[eb] == nByte, tg, "memory after write", mem[eb], nByte);
        end
        check(flags == fM, tg, "flags after op", flags, fM);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule